// File: doc/BRIEF.md
# UART Receive Flow-Control Controller

This block performs automatic flow control for a single UART channel. It compares the receive FIFO occupancy with a high and a low threshold that form a hysteresis band. In hardware mode it throttles the far end through an active-low request output. In software mode it asks the local transmitter to send pause or resume characters. It also holds back the local transmitter at character boundaries, either when the far end drives the active-low clear input high or when the far end sends an in-band pause pattern.

Every received character passes through a pattern matcher before it reaches the receive FIFO. The matcher compares the character against programmed pause and resume patterns, either one character long or two characters in sequence. Only the bits within the configured word length take part in the comparison. Characters that match a pattern are absorbed and never forwarded. The serializer, the FIFOs and the host register file are outside this block.

Top module: `uart_rx_flowctl`

## Requirements
- R1: After reset, `rts_n` and `dtr_n` are 1, `tx_hold`, `ctl_req_valid`, `remote_paused`, `cts_flag` and `rx_fwd_valid` are 0, and all four pattern registers hold 0x00. As a result, a received 0x00 in single mode with 8-bit words is taken as a pause pattern.
- R2: With `cfg_ext_mode`=1, the block enters the throttled state on the clock after `fifo_level` >= `cfg_hi_thr`. It leaves that state on the clock after `fifo_level` <= `cfg_lo_thr`, and between the two thresholds it keeps its state. When hardware flow is enabled, the throttled state drives the selected request output to 1 and the unthrottled state drives it to 0.
- R3: With `cfg_ext_mode`=0, `cfg_legacy_sel` selects the (high, low) threshold pair: 0 gives (8,0), 1 gives (16,7), 2 gives (24,15) and 3 gives (28,23).
- R4: With `cfg_use_dtr`=1, `dtr_n` carries the request output and `dsr_n` is the clear input, while `rts_n` stays 1 and `cts_n` is ignored. With `cfg_use_dtr`=0 the roles are reversed. Whenever hardware flow is off, both request outputs are 1.
- R5: `tx_hold` changes only on a clock where `tx_active` is 0, and it never changes while `tx_active` is 1. When it updates, it becomes 1 if hardware flow is on and the selected clear input is 1, or if `remote_paused` is 1. Otherwise it becomes 0.
- R6: A 0-to-1 edge on the selected clear input sets `cts_flag` when both `cfg_hw_en` and `cfg_cts_irq_en` are 1. The flag stays set until `cts_flag_clr` is pulsed.
- R7: With `cfg_sw_tx_en`=1, entering the throttled state queues the pause pattern and leaving it queues the resume pattern. The block then holds `ctl_req_valid` with `ctl_req_char` until `ctl_req_ack`. In double mode the first pattern character is sent, and after the first acknowledge the second character follows. A new crossing replaces any pending request.
- R8: In single mode (`cfg_sw_rx_en`=1, `cfg_sw_double`=0), a character matches a pattern when the two agree in their low bits. `cfg_wlen` sets how many low bits are compared: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. The match uses the first pattern register of each kind, address 0 for pause and address 2 for resume.
- R9: In double mode, a pause needs the first pause pattern followed by the second pause pattern (address 1), and a resume needs the first resume pattern followed by the second resume pattern (address 3). If the second character does not match, the held first character is forwarded. The new character is then forwarded one cycle later, unless it starts a new pair.
- R10: A character that does not match is forwarded on `rx_fwd_char` with `rx_fwd_valid` on the clock after `rx_valid`. Characters consumed as patterns are never forwarded. When `cfg_sw_rx_en`=0, every character passes through unchanged.
- R11: A matched pause pattern sets `remote_paused`, and a matched resume pattern clears it. If a single-mode character matches both patterns, the pause wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hw_en | input | 1 | Enables hardware handshake |
| cfg_use_dtr | input | 1 | Moves the handshake to the DTR/DSR pair |
| cfg_sw_tx_en | input | 1 | Enables sending pause/resume characters |
| cfg_sw_rx_en | input | 1 | Enables matching received patterns |
| cfg_sw_double | input | 1 | Two-character patterns |
| cfg_ext_mode | input | 1 | Programmable thresholds (1) or legacy pairs (0) |
| cfg_legacy_sel | input | 2 | Legacy threshold pair selector |
| cfg_hi_thr | input | 8 | High threshold, 1 to 128 |
| cfg_lo_thr | input | 8 | Low threshold, below the high one |
| cfg_wlen | input | 2 | Word length code, 5 to 8 bits |
| cfg_cts_irq_en | input | 1 | Enables the clear-edge flag |
| pat_we | input | 1 | Pattern register write strobe |
| pat_addr | input | 2 | 0 pause1, 1 pause2, 2 resume1, 3 resume2 |
| pat_wdata | input | 8 | Pattern write data |
| fifo_level | input | 8 | Receive FIFO occupancy |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character, bit 0 first on the line |
| rx_fwd_valid | output | 1 | Push strobe to the receive FIFO |
| rx_fwd_char | output | 8 | Character pushed to the receive FIFO |
| cts_n | input | 1 | Active-low clear-to-send input |
| dsr_n | input | 1 | Active-low data-set-ready input |
| rts_n | output | 1 | Active-low request-to-send output |
| dtr_n | output | 1 | Active-low data-terminal-ready output |
| tx_active | input | 1 | Transmitter is shifting a character |
| tx_hold | output | 1 | Transmitter must not start a new character |
| ctl_req_valid | output | 1 | Control character request pending |
| ctl_req_char | output | 8 | Control character to transmit |
| ctl_req_ack | input | 1 | Transmitter accepted the request |
| cts_flag | output | 1 | Sticky clear-input rising-edge flag |
| cts_flag_clr | input | 1 | Clears `cts_flag` |
| remote_paused | output | 1 | Far end has paused the transmitter |

## Verification
The matcher assumes that `rx_valid` is never high on two consecutive clocks. A deferred forward uses the idle cycle that follows each character, and the pass-through property relies on it. The bench therefore leaves at least one idle clock after every received character. `ctl_req_ack` is taken to arrive only while a request is valid, and the bench pulses it only in that state. The thresholds are assumed ordered, high above low, and every programmed pair in the bench respects that ordering.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;

    localparam int FC_CHAR_W = 8;
    localparam int FC_LVL_W  = 8;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_STOP = 2'd1,
        REQ_GO   = 2'd2
    } req_kind_e;

    typedef struct packed {
        logic [FC_LVL_W-1:0] hi;
        logic [FC_LVL_W-1:0] lo;
    } thr_pair_t;

    function automatic logic [FC_CHAR_W-1:0] wlen_mask(input logic [1:0] w);
        logic [FC_CHAR_W-1:0] m;
        m = '1;
        return m >> (2'd3 - w);
    endfunction

    function automatic thr_pair_t legacy_pair(input logic [1:0] sel);
        thr_pair_t p;
        case (sel)
            2'd0:    begin p.hi = 8'd8;  p.lo = 8'd0;  end
            2'd1:    begin p.hi = 8'd16; p.lo = 8'd7;  end
            2'd2:    begin p.hi = 8'd24; p.lo = 8'd15; end
            default: begin p.hi = 8'd28; p.lo = 8'd23; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/flowctl_level.sv
module flowctl_level
    import flowctl_pkg::*;
#(
    parameter int LVL_W  = FC_LVL_W,
    parameter int CHAR_W = FC_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              use_dtr,
    input  logic              sw_tx_en,
    input  logic              sw_double,
    input  logic              ext_mode,
    input  logic [1:0]        legacy_sel,
    input  logic [LVL_W-1:0]  hi_thr,
    input  logic [LVL_W-1:0]  lo_thr,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [CHAR_W-1:0] stop1,
    input  logic [CHAR_W-1:0] stop2,
    input  logic [CHAR_W-1:0] go1,
    input  logic [CHAR_W-1:0] go2,
    input  logic              req_ack,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              req_valid,
    output logic [CHAR_W-1:0] req_char
);

    typedef struct packed {
        logic      throttled;
        logic      rts_n;
        logic      dtr_n;
        req_kind_e kind;
        logic      second;
    } lvl_state_t;

    lvl_state_t st_q, st_d;
    thr_pair_t  leg;
    logic [LVL_W-1:0] hi_eff, lo_eff;
    logic rise, fall;

    always_comb begin
        leg    = legacy_pair(legacy_sel);
        hi_eff = ext_mode ? hi_thr : leg.hi;
        lo_eff = ext_mode ? lo_thr : leg.lo;

        st_d = st_q;
        if (st_q.throttled)
            st_d.throttled = !(fifo_level <= lo_eff);
        else
            st_d.throttled = (fifo_level >= hi_eff);

        rise = st_d.throttled && !st_q.throttled;
        fall = !st_d.throttled && st_q.throttled;

        st_d.rts_n = (hw_en && !use_dtr) ? st_d.throttled : 1'b1;
        st_d.dtr_n = (hw_en && use_dtr)  ? st_d.throttled : 1'b1;

        if (req_ack && st_q.kind != REQ_NONE) begin
            if (sw_double && !st_q.second) begin
                st_d.second = 1'b1;
            end else begin
                st_d.kind   = REQ_NONE;
                st_d.second = 1'b0;
            end
        end
        if (sw_tx_en && rise) begin
            st_d.kind   = REQ_STOP;
            st_d.second = 1'b0;
        end else if (sw_tx_en && fall) begin
            st_d.kind   = REQ_GO;
            st_d.second = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.throttled <= 1'b0;
            st_q.rts_n     <= 1'b1;
            st_q.dtr_n     <= 1'b1;
            st_q.kind      <= REQ_NONE;
            st_q.second    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rts_n     = st_q.rts_n;
    assign dtr_n     = st_q.dtr_n;
    assign req_valid = (st_q.kind != REQ_NONE);
    assign req_char  = (st_q.kind == REQ_STOP) ? (st_q.second ? stop2 : stop1)
                                               : (st_q.second ? go2 : go1);

    // R2
    rts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && !use_dtr && fifo_level >= hi_eff) |=> rts_n);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> req_valid);

endmodule

// File: rtl/flowctl_match.sv
module flowctl_match
    import flowctl_pkg::*;
#(
    parameter int CHAR_W = FC_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              dbl,
    input  logic [1:0]        wlen,
    input  logic              pat_we,
    input  logic [1:0]        pat_addr,
    input  logic [CHAR_W-1:0] pat_wdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              fwd_valid,
    output logic [CHAR_W-1:0] fwd_char,
    output logic              paused,
    output logic [CHAR_W-1:0] stop1,
    output logic [CHAR_W-1:0] stop2,
    output logic [CHAR_W-1:0] go1,
    output logic [CHAR_W-1:0] go2
);

    localparam int NPAT = 4;

    typedef struct packed {
        logic [NPAT-1:0][CHAR_W-1:0] pat;
        logic              held_v;
        logic              held_go;
        logic [CHAR_W-1:0] held_char;
        logic              pend_v;
        logic [CHAR_W-1:0] pend_char;
        logic              fwd_v;
        logic [CHAR_W-1:0] fwd_char;
        logic              paused;
    } m_state_t;

    m_state_t st_q, st_d;
    logic [CHAR_W-1:0] mask, mc;
    logic hit_s1, hit_s2, hit_g1, hit_g2;

    always_comb begin
        mask   = wlen_mask(wlen);
        mc     = rx_char & mask;
        hit_s1 = (mc == (st_q.pat[0] & mask));
        hit_s2 = (mc == (st_q.pat[1] & mask));
        hit_g1 = (mc == (st_q.pat[2] & mask));
        hit_g2 = (mc == (st_q.pat[3] & mask));

        st_d       = st_q;
        st_d.fwd_v = 1'b0;
        if (pat_we)
            st_d.pat[pat_addr] = pat_wdata;

        if (rx_valid) begin
            if (!rx_en) begin
                st_d.fwd_v    = 1'b1;
                st_d.fwd_char = rx_char;
            end else if (!dbl) begin
                if (hit_s1)      st_d.paused = 1'b1;
                else if (hit_g1) st_d.paused = 1'b0;
                else begin
                    st_d.fwd_v    = 1'b1;
                    st_d.fwd_char = rx_char;
                end
            end else if (st_q.held_v && !st_q.held_go && hit_s2) begin
                st_d.paused = 1'b1;
                st_d.held_v = 1'b0;
            end else if (st_q.held_v && st_q.held_go && hit_g2) begin
                st_d.paused = 1'b0;
                st_d.held_v = 1'b0;
            end else begin
                if (st_q.held_v) begin
                    st_d.fwd_v    = 1'b1;
                    st_d.fwd_char = st_q.held_char;
                end
                st_d.held_v = 1'b0;
                if (hit_s1 || hit_g1) begin
                    st_d.held_v    = 1'b1;
                    st_d.held_go   = !hit_s1;
                    st_d.held_char = rx_char;
                end else if (st_q.held_v) begin
                    st_d.pend_v    = 1'b1;
                    st_d.pend_char = rx_char;
                end else begin
                    st_d.fwd_v    = 1'b1;
                    st_d.fwd_char = rx_char;
                end
            end
        end else if (st_q.pend_v) begin
            st_d.fwd_v    = 1'b1;
            st_d.fwd_char = st_q.pend_char;
            st_d.pend_v   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fwd_valid = st_q.fwd_v;
    assign fwd_char  = st_q.fwd_char;
    assign paused    = st_q.paused;
    assign stop1     = st_q.pat[0];
    assign stop2     = st_q.pat[1];
    assign go1       = st_q.pat[2];
    assign go2       = st_q.pat[3];

    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_en && !st_q.pend_v && !st_q.held_v)
            |=> (fwd_valid && fwd_char == $past(rx_char)));

    // R11
    pause_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(rx_valid));

endmodule

// File: rtl/flowctl_txgate.sv
module flowctl_txgate (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_en,
    input  logic use_dtr,
    input  logic cts_n,
    input  logic dsr_n,
    input  logic irq_en,
    input  logic flag_clr,
    input  logic tx_active,
    input  logic remote_paused,
    output logic tx_hold,
    output logic flag
);

    typedef struct packed {
        logic hold;
        logic prev;
        logic flag;
    } g_state_t;

    g_state_t st_q, st_d;
    logic sel_in, rise;

    always_comb begin
        sel_in = use_dtr ? dsr_n : cts_n;
        rise   = sel_in && !st_q.prev;

        st_d      = st_q;
        st_d.prev = sel_in;
        if (!tx_active)
            st_d.hold = (hw_en && sel_in) || remote_paused;
        if (flag_clr)
            st_d.flag = 1'b0;
        else if (rise && hw_en && irq_en)
            st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b0;
            st_q.prev <= 1'b1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_hold = st_q.hold;
    assign flag    = st_q.flag;

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> $stable(tx_hold));

    // R6
    flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(irq_en) && $past(hw_en)));

endmodule

// File: rtl/uart_rx_flowctl.sv
module uart_rx_flowctl
    import flowctl_pkg::*;
#(
    parameter int LVL_W  = FC_LVL_W,
    parameter int CHAR_W = FC_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hw_en,
    input  logic              cfg_use_dtr,
    input  logic              cfg_sw_tx_en,
    input  logic              cfg_sw_rx_en,
    input  logic              cfg_sw_double,
    input  logic              cfg_ext_mode,
    input  logic [1:0]        cfg_legacy_sel,
    input  logic [LVL_W-1:0]  cfg_hi_thr,
    input  logic [LVL_W-1:0]  cfg_lo_thr,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_cts_irq_en,
    input  logic              pat_we,
    input  logic [1:0]        pat_addr,
    input  logic [CHAR_W-1:0] pat_wdata,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              rx_fwd_valid,
    output logic [CHAR_W-1:0] rx_fwd_char,
    input  logic              cts_n,
    input  logic              dsr_n,
    output logic              rts_n,
    output logic              dtr_n,
    input  logic              tx_active,
    output logic              tx_hold,
    output logic              ctl_req_valid,
    output logic [CHAR_W-1:0] ctl_req_char,
    input  logic              ctl_req_ack,
    output logic              cts_flag,
    input  logic              cts_flag_clr,
    output logic              remote_paused
);

    logic [CHAR_W-1:0] stop1, stop2, go1, go2;

    flowctl_match #(.CHAR_W(CHAR_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .rx_en(cfg_sw_rx_en), .dbl(cfg_sw_double), .wlen(cfg_wlen),
        .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
        .rx_valid(rx_valid), .rx_char(rx_char),
        .fwd_valid(rx_fwd_valid), .fwd_char(rx_fwd_char),
        .paused(remote_paused),
        .stop1(stop1), .stop2(stop2), .go1(go1), .go2(go2)
    );

    flowctl_level #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) u_level (
        .clk(clk), .rst_n(rst_n),
        .hw_en(cfg_hw_en), .use_dtr(cfg_use_dtr),
        .sw_tx_en(cfg_sw_tx_en), .sw_double(cfg_sw_double),
        .ext_mode(cfg_ext_mode), .legacy_sel(cfg_legacy_sel),
        .hi_thr(cfg_hi_thr), .lo_thr(cfg_lo_thr), .fifo_level(fifo_level),
        .stop1(stop1), .stop2(stop2), .go1(go1), .go2(go2),
        .req_ack(ctl_req_ack),
        .rts_n(rts_n), .dtr_n(dtr_n),
        .req_valid(ctl_req_valid), .req_char(ctl_req_char)
    );

    flowctl_txgate u_gate (
        .clk(clk), .rst_n(rst_n),
        .hw_en(cfg_hw_en), .use_dtr(cfg_use_dtr),
        .cts_n(cts_n), .dsr_n(dsr_n),
        .irq_en(cfg_cts_irq_en), .flag_clr(cts_flag_clr),
        .tx_active(tx_active), .remote_paused(remote_paused),
        .tx_hold(tx_hold), .flag(cts_flag)
    );

endmodule

// File: tb/sim_uart_rx_flowctl.sv
module sim_uart_rx_flowctl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_hw_en, cfg_use_dtr, cfg_sw_tx_en, cfg_sw_rx_en, cfg_sw_double;
    logic       cfg_ext_mode, cfg_cts_irq_en;
    logic [1:0] cfg_legacy_sel, cfg_wlen;
    logic [7:0] cfg_hi_thr, cfg_lo_thr;
    logic       pat_we;
    logic [1:0] pat_addr;
    logic [7:0] pat_wdata, fifo_level, rx_char, rx_fwd_char, ctl_req_char;
    logic       rx_valid, rx_fwd_valid, cts_n, dsr_n, rts_n, dtr_n;
    logic       tx_active, tx_hold, ctl_req_valid, ctl_req_ack;
    logic       cts_flag, cts_flag_clr, remote_paused;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_flowctl u0 (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_hw_en = 0; cfg_use_dtr = 0; cfg_sw_tx_en = 0; cfg_sw_rx_en = 0;
        cfg_sw_double = 0; cfg_ext_mode = 1; cfg_cts_irq_en = 0;
        cfg_legacy_sel = 0; cfg_wlen = 2'd3; cfg_hi_thr = 8'd10; cfg_lo_thr = 8'd4;
        pat_we = 0; pat_addr = 0; pat_wdata = 0; fifo_level = 0;
        rx_valid = 0; rx_char = 0; cts_n = 0; dsr_n = 0; tx_active = 0;
        ctl_req_ack = 0; cts_flag_clr = 0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_pat(input logic [1:0] a, input logic [7:0] d);
        pat_we = 1; pat_addr = a; pat_wdata = d;
        step();
        pat_we = 0;
    endtask

    task automatic send(input logic [7:0] c);
        rx_valid = 1; rx_char = c;
        step();
        rx_valid = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 rts_n", rts_n, 1);
        check("R1 dtr_n", dtr_n, 1);
        check("R1 tx_hold", tx_hold, 0);
        check("R1 req_valid", ctl_req_valid, 0);
        check("R1 paused", remote_paused, 0);
        check("R1 flag", cts_flag, 0);
        check("R1 fwd", rx_fwd_valid, 0);
        cfg_sw_rx_en = 1;
        send(8'h00);
        check("R1 zero pattern pauses", remote_paused, 1);
        check("R1 zero pattern dropped", rx_fwd_valid, 0);
        step();
    endtask

    task automatic t_hw_ext();
        do_reset();
        cfg_hw_en = 1;
        fifo_level = 9;  step(); check("R2 below hi", rts_n, 0);
        fifo_level = 10; step(); check("R2 at hi", rts_n, 1);
        fifo_level = 5;  step(); check("R2 in band", rts_n, 1);
        fifo_level = 4;  step(); check("R2 at lo", rts_n, 0);
        fifo_level = 8;  step(); check("R2 band from below", rts_n, 0);
    endtask

    task automatic t_legacy();
        do_reset();
        cfg_hw_en = 1; cfg_ext_mode = 0;
        for (int s = 0; s < 4; s++) begin
            int hi, lo;
            case (s)
                0: begin hi = 8;  lo = 0;  end
                1: begin hi = 16; lo = 7;  end
                2: begin hi = 24; lo = 15; end
                default: begin hi = 28; lo = 23; end
            endcase
            cfg_legacy_sel = 2'(s);
            fifo_level = 8'(lo); step(); check("R3 start", rts_n, 0);
            fifo_level = 8'(hi - 1); step(); check("R3 below hi", rts_n, 0);
            fifo_level = 8'(hi); step(); check("R3 hi", rts_n, 1);
            fifo_level = 8'(lo + 1); step(); check("R3 above lo", rts_n, 1);
            fifo_level = 8'(lo); step(); check("R3 lo", rts_n, 0);
        end
    endtask

    task automatic t_dtr();
        do_reset();
        cfg_hw_en = 1; cfg_use_dtr = 1;
        fifo_level = 10; step();
        check("R4 dtr throttled", dtr_n, 1);
        check("R4 rts unused", rts_n, 1);
        fifo_level = 4; step();
        check("R4 dtr open", dtr_n, 0);
        check("R4 rts unused", rts_n, 1);
        cts_n = 1; step();
        check("R4 cts ignored", tx_hold, 0);
        dsr_n = 1; step();
        check("R4 dsr holds", tx_hold, 1);
    endtask

    task automatic t_hold();
        do_reset();
        cfg_hw_en = 1;
        tx_active = 1; cts_n = 1; step();
        check("R5 hold waits for boundary", tx_hold, 0);
        tx_active = 0; step();
        check("R5 hold at boundary", tx_hold, 1);
        cts_n = 0; tx_active = 1; step();
        check("R5 release waits", tx_hold, 1);
        tx_active = 0; step();
        check("R5 released", tx_hold, 0);
    endtask

    task automatic t_edge();
        do_reset();
        cfg_hw_en = 1;
        cts_n = 1; step(); check("R6 edge without enable", cts_flag, 0);
        cts_n = 0; step();
        cfg_cts_irq_en = 1;
        cts_n = 1; step(); check("R6 edge sets", cts_flag, 1);
        cts_n = 0; step(); check("R6 sticky", cts_flag, 1);
        cts_flag_clr = 1; step(); cts_flag_clr = 0;
        check("R6 cleared", cts_flag, 0);
    endtask

    task automatic t_swtx();
        do_reset();
        write_pat(0, 8'h13); write_pat(1, 8'h14);
        write_pat(2, 8'h11); write_pat(3, 8'h12);
        cfg_sw_tx_en = 1;
        fifo_level = 10; step();
        check("R7 stop valid", ctl_req_valid, 1);
        check("R7 stop char", ctl_req_char, 8'h13);
        ctl_req_ack = 1; step(); ctl_req_ack = 0;
        check("R7 acked", ctl_req_valid, 0);
        fifo_level = 4; step();
        check("R7 go char", ctl_req_char, 8'h11);
        ctl_req_ack = 1; step(); ctl_req_ack = 0;
        cfg_sw_double = 1;
        fifo_level = 10; step();
        check("R7 double first", ctl_req_char, 8'h13);
        ctl_req_ack = 1; step(); ctl_req_ack = 0;
        check("R7 double second valid", ctl_req_valid, 1);
        check("R7 double second", ctl_req_char, 8'h14);
        ctl_req_ack = 1; step(); ctl_req_ack = 0;
        check("R7 double done", ctl_req_valid, 0);
        fifo_level = 4; step();
        check("R7 go pending", ctl_req_char, 8'h11);
        fifo_level = 10; step();
        check("R7 latest wins valid", ctl_req_valid, 1);
        check("R7 latest wins char", ctl_req_char, 8'h13);
    endtask

    task automatic t_single();
        do_reset();
        write_pat(0, 8'h13); write_pat(2, 8'h11);
        cfg_sw_rx_en = 1; cfg_hw_en = 1;
        send(8'h13);
        check("R10 stop dropped", rx_fwd_valid, 0);
        check("R11 paused", remote_paused, 1);
        step();
        check("R5 remote pause holds tx", tx_hold, 1);
        send(8'h41);
        check("R10 data forwarded", rx_fwd_valid, 1);
        check("R10 data value", rx_fwd_char, 8'h41);
        step();
        send(8'h11);
        check("R11 resumed", remote_paused, 0);
        check("R10 go dropped", rx_fwd_valid, 0);
        step();
        send(8'hF3);
        check("R8 8-bit no match", rx_fwd_char, 8'hF3);
        check("R8 8-bit still running", remote_paused, 0);
        step();
        cfg_wlen = 2'd0;
        send(8'hF3);
        check("R8 5-bit match", remote_paused, 1);
        check("R8 5-bit dropped", rx_fwd_valid, 0);
        step();
        send(8'h31);
        check("R8 5-bit go", remote_paused, 0);
        step();
        cfg_sw_rx_en = 0; cfg_wlen = 2'd3;
        send(8'h13);
        check("R10 disabled passes", rx_fwd_char, 8'h13);
        check("R10 disabled no pause", remote_paused, 0);
        step();
    endtask

    task automatic t_double();
        do_reset();
        write_pat(0, 8'hA1); write_pat(1, 8'hA2);
        write_pat(2, 8'hB1); write_pat(3, 8'hB2);
        cfg_sw_rx_en = 1; cfg_sw_double = 1;
        send(8'hA1); check("R9 first held", rx_fwd_valid, 0); step();
        check("R9 half not paused", remote_paused, 0);
        send(8'hA2); check("R9 pair pauses", remote_paused, 1);
        check("R9 pair dropped", rx_fwd_valid, 0); step();
        send(8'hB1); step();
        send(8'h55);
        check("R9 held released", rx_fwd_valid, 1);
        check("R9 held char", rx_fwd_char, 8'hB1);
        step();
        check("R9 next char valid", rx_fwd_valid, 1);
        check("R9 next char", rx_fwd_char, 8'h55);
        check("R9 still paused", remote_paused, 1);
        send(8'hB1); step();
        send(8'hB2); check("R9 resume pair", remote_paused, 0); step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_hw_ext();
        t_legacy();
        t_dtr();
        t_hold();
        t_edge();
        t_swtx();
        t_single();
        t_double();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule